// File: doc/BRIEF.md
# Endian Lane Mapper

This block sits between a load/store unit and a 64-bit memory word whose byte lanes are numbered in little-endian order: lane k holds bits 8k+7 down to 8k. For each access it takes the byte address within the word, the access size and the endian select. It returns the loaded value zero-extended to 64 bits. For a store it returns the byte enables and the store data steered into the right lanes.

Big-endian accesses can follow one of four mappings. Under address invariance, every byte keeps its address and only the significance of the bytes in a wider value is reversed. Under data invariance at half-word, word or double-word granularity, a datum of that size has the same value in both endian modes. Narrower accesses inside such a datum see their byte addresses mirrored. Only the order of bytes ever changes; the bits and nibbles inside a byte are never moved. An access whose address is not a multiple of its size is flagged and not served. All results are registered, so they appear one clock after the inputs.

Top module: `endian_lane_mapper`

## Requirements
- R1: With `big_end` = 0, a read of S bytes at address A returns memory lanes A..A+S-1, with lane A in the least significant byte. `acc_size` encodes S as 0 = 1, 1 = 2, 2 = 4, 3 = 8 bytes.
- R2: With `big_end` = 1 and `inv_mode` = 0 (address invariance), a read returns the same lanes as R1 with the byte order reversed. A single byte is unchanged. On the word 0x99887766_ddccbbaa, 2 bytes at 0 read 0xaabb and 4 bytes at 0 read 0xaabbccdd.
- R3: With `big_end` = 1 and `inv_mode` = 1 (half-word invariance), reads of 2 bytes or more equal the R1 result. A byte read uses lane A XOR 1, so address 0 reads 0xbb.
- R4: With `big_end` = 1 and `inv_mode` = 2 (word invariance), reads of 4 and 8 bytes equal the R1 result. A read of S < 4 bytes starts at lane A XOR (4 - S): address 0 reads 0xdd as one byte and 0xddcc as two bytes.
- R5: With `big_end` = 1 and `inv_mode` = 3 (double-word invariance), only the 8-byte read equals the R1 result. A read of S < 8 bytes starts at lane A XOR (8 - S): address 0 reads 0x99, 0x9988 and 0x99887766.
- R6: Every bit of `rd_data` above the access width is zero, in every mode.
- R7: If A is not a multiple of S, `misalign` is 1 and `rd_data`, `wr_be` and `wr_lanes` are all zero. Otherwise `misalign` is 0.
- R8: For an aligned access, `wr_be` has exactly S bits set. They are the contiguous lanes that a read with the same inputs would fetch.
- R9: For an aligned access, `wr_lanes` holds the low S bytes of `wr_data` in the enabled lanes. The byte order is reversed under address-invariant big-endian and unchanged otherwise. Lanes without an enable are zero.
- R10: Outputs are zero while `rst_n` is low. Each result appears after exactly one rising clock edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| mem_word | input | 64 | Memory word, lane k in bits 8k+7:8k |
| byte_addr | input | 3 | Byte address within the word |
| acc_size | input | 2 | Access size: 0 = 1, 1 = 2, 2 = 4, 3 = 8 bytes |
| big_end | input | 1 | 1 selects big-endian interpretation |
| inv_mode | input | 2 | 0 = address invariance, 1 = half-word, 2 = word, 3 = double-word data invariance |
| wr_data | input | 64 | Store value, low S bytes used |
| rd_data | output | 64 | Zero-extended load result |
| wr_be | output | 8 | Byte enable per lane |
| wr_lanes | output | 64 | Store data placed in lanes |
| misalign | output | 1 | Access not aligned to its size |

## Verification
The assertions check several properties on every cycle. A misaligned result carries no data and no enables. The number of enables matches the registered access size. No data appears outside the enabled lanes or above the access width. A little-endian byte load returns the addressed lane. The mode-specific orderings can only be shown by the bench's scenarios, which compare fixed results from a known word under each of the four big-endian mappings. These are the mirrored addresses under each data-invariance granularity, the reversed significance under address invariance, and the store lanes those mappings select.

// File: rtl/endian_lane_mapper.sv
module endian_lane_mapper #(
  parameter int LANES = 8,
  localparam int AW = $clog2(LANES),
  localparam int SW = $clog2(AW + 1),
  localparam int DW = LANES * 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [DW-1:0] mem_word,
  input  logic [AW-1:0] byte_addr,
  input  logic [SW-1:0] acc_size,
  input  logic          big_end,
  input  logic [SW-1:0] inv_mode,
  input  logic [DW-1:0] wr_data,
  output logic [DW-1:0] rd_data,
  output logic [LANES-1:0] wr_be,
  output logic [DW-1:0] wr_lanes,
  output logic          misalign
);

  logic [AW:0] nbytes, szm1, dsize, dmn;
  logic        bad, swap, remap;
  logic [AW-1:0] base;

  assign nbytes = (AW+1)'(1) << acc_size;
  assign szm1   = nbytes - (AW+1)'(1);
  assign dsize  = (AW+1)'(1) << inv_mode;
  assign dmn    = dsize - nbytes;
  assign bad    = |(byte_addr & szm1[AW-1:0]);
  assign swap   = big_end && (inv_mode == '0);
  assign remap  = big_end && (inv_mode != '0) && (nbytes < dsize);
  assign base   = remap ? (byte_addr ^ dmn[AW-1:0]) : byte_addr;

  logic [DW-1:0]    rd_n, ln_n;
  logic [LANES-1:0] be_n;

  always_comb begin
    logic [AW:0]   sel;
    logic [AW-1:0] lane;
    rd_n = '0;
    ln_n = '0;
    be_n = '0;
    sel  = '0;
    lane = '0;
    for (int k = 0; k < LANES; k++) begin
      if (!bad && ((AW+1)'(k) < nbytes)) begin
        sel  = swap ? (szm1 - (AW+1)'(k)) : (AW+1)'(k);
        lane = base + sel[AW-1:0];
        rd_n[8*k +: 8] = mem_word[8*lane +: 8];
        lane = base + AW'(k);
        be_n[lane] = 1'b1;
        ln_n[8*lane +: 8] = wr_data[8*sel +: 8];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_data  <= '0;
      wr_be    <= '0;
      wr_lanes <= '0;
      misalign <= 1'b0;
    end else begin
      rd_data  <= rd_n;
      wr_be    <= be_n;
      wr_lanes <= ln_n;
      misalign <= bad;
    end
  end

endmodule

// File: rtl/endian_lane_mapper_chk.sv
module endian_lane_mapper_chk #(
  parameter int LANES = 8,
  localparam int AW = $clog2(LANES),
  localparam int SW = $clog2(AW + 1),
  localparam int DW = LANES * 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic [DW-1:0]    mem_word,
  input logic [AW-1:0]    byte_addr,
  input logic [SW-1:0]    acc_size,
  input logic             big_end,
  input logic [DW-1:0]    rd_data,
  input logic [LANES-1:0] wr_be,
  input logic [DW-1:0]    wr_lanes,
  input logic             misalign
);

  logic primed;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) primed <= 1'b0;
    else        primed <= 1'b1;
  end

  logic [DW-1:0] be_mask;
  always_comb begin
    be_mask = '0;
    for (int k = 0; k < LANES; k++) be_mask[8*k +: 8] = {8{wr_be[k]}};
  end

  // R7
  misalign_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    misalign |-> (rd_data == '0 && wr_be == '0 && wr_lanes == '0));

  // R8
  enable_count_chk: assert property (@(posedge clk) disable iff (!rst_n || !primed)
    !misalign |-> $countones(wr_be) == (1 << $past(acc_size)));

  // R6
  zero_extend_chk: assert property (@(posedge clk) disable iff (!rst_n || !primed)
    (!misalign && $past(acc_size) != SW'(AW)) |->
      (rd_data >> (8 << $past(acc_size))) == '0);

  // R9
  lanes_inside_enables_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_lanes & ~be_mask) == '0);

  // R1
  le_byte_load_chk: assert property (@(posedge clk) disable iff (!rst_n || !primed)
    (!misalign && !$past(big_end) && $past(acc_size) == '0) |->
      rd_data[7:0] == 8'($past(mem_word) >> {$past(byte_addr), 3'b000}));

endmodule

bind endian_lane_mapper endian_lane_mapper_chk #(.LANES(LANES)) u_chk (
  .clk(clk), .rst_n(rst_n), .mem_word(mem_word), .byte_addr(byte_addr),
  .acc_size(acc_size), .big_end(big_end), .rd_data(rd_data),
  .wr_be(wr_be), .wr_lanes(wr_lanes), .misalign(misalign)
);

// File: tb/endian_lane_mapper_bench.sv
module endian_lane_mapper_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [63:0] mem_word = 64'h9988_7766_ddcc_bbaa;
  logic [2:0]  byte_addr = '0;
  logic [1:0]  acc_size = '0;
  logic        big_end = 1'b0;
  logic [1:0]  inv_mode = '0;
  logic [63:0] wr_data = '0;
  logic [63:0] rd_data, wr_lanes;
  logic [7:0]  wr_be;
  logic        misalign;
  int checks = 0, errors = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  endian_lane_mapper u_endian_lane_mapper (
    .clk(clk), .rst_n(rst_n), .mem_word(mem_word), .byte_addr(byte_addr),
    .acc_size(acc_size), .big_end(big_end), .inv_mode(inv_mode), .wr_data(wr_data),
    .rd_data(rd_data), .wr_be(wr_be), .wr_lanes(wr_lanes), .misalign(misalign));

  task automatic check(string tag, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic access(bit be, logic [1:0] im, logic [1:0] sz, logic [2:0] a, logic [63:0] wd);
    @(negedge clk);
    big_end = be; inv_mode = im; acc_size = sz; byte_addr = a; wr_data = wd;
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic rd(string tag, bit be, logic [1:0] im, logic [1:0] sz, logic [2:0] a, logic [63:0] exp);
    access(be, im, sz, a, '0);
    check(tag, rd_data, exp);
    check({tag, " misalign"}, {63'd0, misalign}, 64'd0);
  endtask

  task automatic t_reset;
    @(negedge clk);
    check("R10 reset rd_data", rd_data, 64'd0);
    check("R10 reset wr_be", {56'd0, wr_be}, 64'd0);
    check("R10 reset misalign", {63'd0, misalign}, 64'd0);
    rst_n = 1'b1;
  endtask

  task automatic t_little;
    rd("R1 LE byte a3", 0, 0, 0, 3, 64'hdd);
    rd("R1 LE half a2", 0, 0, 1, 2, 64'hddcc);
    rd("R1 LE word a4", 0, 3, 2, 4, 64'h9988_7766);
    rd("R1 LE dword", 0, 2, 3, 0, 64'h9988_7766_ddcc_bbaa);
  endtask

  task automatic t_addr_inv;
    rd("R2 AI byte a0", 1, 0, 0, 0, 64'haa);
    rd("R2 AI half a0", 1, 0, 1, 0, 64'haabb);
    rd("R2 AI word a0", 1, 0, 2, 0, 64'haabb_ccdd);
    rd("R6 R2 AI dword", 1, 0, 3, 0, 64'haabb_ccdd_6677_8899);
  endtask

  task automatic t_half;
    rd("R3 HW byte a0", 1, 1, 0, 0, 64'hbb);
    rd("R3 HW byte a1", 1, 1, 0, 1, 64'haa);
    rd("R3 HW half a0", 1, 1, 1, 0, 64'hbbaa);
    rd("R3 HW word a0", 1, 1, 2, 0, 64'hddcc_bbaa);
  endtask

  task automatic t_word;
    rd("R4 W byte a0", 1, 2, 0, 0, 64'hdd);
    rd("R4 W byte a5", 1, 2, 0, 5, 64'h88);
    rd("R4 W half a0", 1, 2, 1, 0, 64'hddcc);
    rd("R4 W half a6", 1, 2, 1, 6, 64'h7766);
    rd("R4 W word a4", 1, 2, 2, 4, 64'h9988_7766);
    rd("R4 W dword", 1, 2, 3, 0, 64'h9988_7766_ddcc_bbaa);
  endtask

  task automatic t_dword;
    rd("R5 D byte a0", 1, 3, 0, 0, 64'h99);
    rd("R5 D half a0", 1, 3, 1, 0, 64'h9988);
    rd("R5 D word a0", 1, 3, 2, 0, 64'h9988_7766);
    rd("R5 D word a4", 1, 3, 2, 4, 64'hddcc_bbaa);
    rd("R5 D dword", 1, 3, 3, 0, 64'h9988_7766_ddcc_bbaa);
  endtask

  task automatic t_misalign;
    access(0, 0, 1, 1, 64'hffff);
    check("R7 half a1 flag", {63'd0, misalign}, 64'd1);
    check("R7 half a1 data", rd_data, 64'd0);
    check("R7 half a1 be", {56'd0, wr_be}, 64'd0);
    access(1, 2, 2, 2, 64'hffff_ffff);
    check("R7 word a2 flag", {63'd0, misalign}, 64'd1);
    check("R7 word a2 lanes", wr_lanes, 64'd0);
    access(1, 3, 3, 4, '1);
    check("R7 dword a4 flag", {63'd0, misalign}, 64'd1);
    check("R7 dword a4 data", rd_data, 64'd0);
  endtask

  task automatic t_write;
    access(0, 0, 1, 2, 64'hffff_ffff_ffff_1122);
    check("R8 LE half a2 be", {56'd0, wr_be}, 64'h0c);
    check("R9 LE half a2 lanes", wr_lanes, 64'h0000_0000_1122_0000);
    access(1, 0, 1, 2, 64'hffff_ffff_ffff_1122);
    check("R8 AI half a2 be", {56'd0, wr_be}, 64'h0c);
    check("R9 AI half a2 lanes", wr_lanes, 64'h0000_0000_2211_0000);
    access(1, 2, 0, 1, 64'hffff_ffff_ffff_ff5a);
    check("R8 W byte a1 be", {56'd0, wr_be}, 64'h04);
    check("R9 W byte a1 lanes", wr_lanes, 64'h0000_0000_005a_0000);
    access(1, 3, 1, 0, 64'hffff_ffff_ffff_1234);
    check("R8 D half a0 be", {56'd0, wr_be}, 64'hc0);
    check("R9 D half a0 lanes", wr_lanes, 64'h1234_0000_0000_0000);
    access(1, 1, 3, 0, 64'h0102_0304_0506_0708);
    check("R8 HW dword be", {56'd0, wr_be}, 64'hff);
    check("R9 HW dword lanes", wr_lanes, 64'h0102_0304_0506_0708);
  endtask

  task automatic finish_run;
    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (3) @(posedge clk);
    t_reset();
    t_little();
    t_addr_inv();
    t_half();
    t_word();
    t_dword();
    t_misalign();
    t_write();
    finish_run();
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
    end
  end
endmodule